// File: doc/BRIEF.md
# Operate Microinstruction Unit

This unit carries out the register-only "operate" instructions of a 12-bit accumulator machine. A single instruction word can set several micro-operation bits at once. The unit applies them in a fixed order over two phases, each started by its own strobe. The surrounding sequencer presents the instruction word, the accumulator and the link bit together with the first strobe. It presents the switch word with the second strobe. It reads back the new accumulator and link, plus one-cycle pulses that ask it to skip the next instruction, to halt, or to trap a privileged operation attempted in user mode.

The accumulator and link outputs are registers. They show the first-phase result after the first strobe and the final result after the second strobe, and they hold steady until the next operate instruction. Two groups are handled. The first group covers clears, complements, the 13-bit increment and the rotates. The second group covers the conditional skip, the accumulator clear, the switch OR and the halt. Any other instruction word is left alone.

Top module: `opr_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, the accumulator output is 0, the link output is 0 and the skip, halt and trap pulses are low.
- R2: A first-phase strobe with an instruction whose bits 11:9 are not 7, or whose bits 8 and 0 are both 1, leaves the accumulator and link unchanged and produces no pulse. A second-phase strobe that follows it also has no effect.
- R3: In group one (bit 8 = 0), the first strobe loads the presented accumulator and link, then applies in order: bit 7 clears the accumulator and bit 6 clears the link; then bit 5 complements the accumulator and bit 4 complements the link. So bits 7 and 5 together give all ones.
- R4: In group one, bit 0 adds 1 to the 13-bit value {link, accumulator} at the second strobe. A carry out of the accumulator therefore toggles the link.
- R5: In group one, bits 3:1 choose a second-phase move of the 13-bit chain {link, accumulator}: 001 swaps the two 6-bit halves of the accumulator and keeps the link; 010 rotates left by one; 011 rotates left by two; 100 rotates right by one; 101 rotates right by two. Codes 000, 110 and 111 leave the chain as it is.
- R6: When bit 0 and a move are both set, the increment is applied first and the move acts on the incremented chain.
- R7: In group two (bit 8 = 1, bit 0 = 0), the skip condition is the OR of three tests: bit 6 with accumulator bit 11 set, bit 5 with the accumulator equal to zero, and bit 4 with the link set. The tests use the values presented at the first strobe. Bit 3 inverts the result. A true result gives a one-cycle skip pulse after the second strobe.
- R8: In group two, bit 7 clears the accumulator at the first strobe. Bit 2 ORs the switch word, as presented at the second strobe, into the accumulator at the second strobe. So bits 7 and 2 together load the switch word.
- R9: In group two with the user flag low at the first strobe, bit 1 gives a one-cycle halt pulse after the second strobe.
- R10: In group two with the user flag high at the first strobe, bits 2 and 1 do not change the accumulator and do not give a halt pulse. A one-cycle trap pulse is given instead if either bit is set.
- R11: Skip, halt and trap pulses last exactly one cycle. In cycles with no strobe, the accumulator and link outputs do not change, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_in | input | 12 | Instruction word, sampled at the first strobe |
| acc_in | input | W | Accumulator value, sampled at the first strobe |
| lnk_in | input | 1 | Link value, sampled at the first strobe |
| sw_in | input | W | Switch word, sampled at the second strobe |
| user_in | input | 1 | User-mode flag, sampled at the first strobe |
| ph1_stb | input | 1 | First-phase strobe (wins if both strobes are high) |
| ph2_stb | input | 1 | Second-phase strobe |
| acc_out | output | W | Accumulator result register |
| lnk_out | output | 1 | Link result register |
| skip_pulse | output | 1 | Request to advance the program counter by two |
| halt_pulse | output | 1 | Halt request |
| trap_pulse | output | 1 | User-mode trap request |

## Verification
The hardest case to reach is a word where several micro-operations interact. Examples are the increment carrying into the link and then being rotated, a clear that must not affect the skip tests, and privileged bits arriving with the user flag set. Uniform random words seldom hit an all-ones accumulator together with an increment, so directed vectors force these boundary values. Random vectors then mix every bit field with random data, strobe gaps and data inputs that change between strobes, so the sampling points of each input are checked as well.

// File: rtl/opr_pkg.sv
`timescale 1ns/1ps
package opr_pkg;

    localparam int unsigned INSTR_W     = 12;
    localparam logic [2:0]  OPC_OPERATE = 3'd7;

    typedef enum logic [1:0] {
        GRP_NONE,
        GRP_ONE,
        GRP_TWO
    } grp_e;

    typedef enum logic [2:0] {
        MV_NONE,
        MV_SWAP,
        MV_ROL1,
        MV_ROL2,
        MV_ROR1,
        MV_ROR2
    } move_e;

    typedef struct packed {
        grp_e  grp;
        logic  clr_acc;
        logic  clr_lnk;
        logic  cpl_acc;
        logic  cpl_lnk;
        logic  inc;
        move_e move;
        logic  t_neg;
        logic  t_zero;
        logic  t_lnk;
        logic  t_inv;
        logic  osr;
        logic  hlt;
    } ctrl_t;

    function automatic move_e move_of(input logic [2:0] code);
        case (code)
            3'b001:  return MV_SWAP;
            3'b010:  return MV_ROL1;
            3'b011:  return MV_ROL2;
            3'b100:  return MV_ROR1;
            3'b101:  return MV_ROR2;
            default: return MV_NONE;
        endcase
    endfunction

    function automatic ctrl_t decode(input logic [INSTR_W-1:0] iw);
        ctrl_t c;
        c = '0;
        c.grp  = GRP_NONE;
        c.move = MV_NONE;
        if (iw[11:9] == OPC_OPERATE) begin
            if (!iw[8]) begin
                c.grp     = GRP_ONE;
                c.clr_acc = iw[7];
                c.clr_lnk = iw[6];
                c.cpl_acc = iw[5];
                c.cpl_lnk = iw[4];
                c.move    = move_of(iw[3:1]);
                c.inc     = iw[0];
            end else if (!iw[0]) begin
                c.grp     = GRP_TWO;
                c.clr_acc = iw[7];
                c.t_neg   = iw[6];
                c.t_zero  = iw[5];
                c.t_lnk   = iw[4];
                c.t_inv   = iw[3];
                c.osr     = iw[2];
                c.hlt     = iw[1];
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/opr_decode.sv
`timescale 1ns/1ps
module opr_decode
    import opr_pkg::*;
(
    input  logic [INSTR_W-1:0] iw,
    output ctrl_t              ctrl
);

    always_comb begin
        ctrl = decode(iw);
    end

endmodule

// File: rtl/opr_first.sv
`timescale 1ns/1ps
module opr_first
    import opr_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  ctrl_t          ctrl,
    input  logic [W-1:0]   acc,
    input  logic           lnk,
    output logic [W-1:0]   acc_o,
    output logic           lnk_o,
    output logic           skip_o
);

    logic cond;

    // Skip tests look at the values as presented, before any clear.
    always_comb begin
        cond = (ctrl.t_neg  && acc[W-1])
             | (ctrl.t_zero && (acc == '0))
             | (ctrl.t_lnk  && lnk);
        skip_o = (ctrl.grp == GRP_TWO) && (cond ^ ctrl.t_inv);
    end

    // Clears take effect before complements.
    always_comb begin
        acc_o = acc;
        lnk_o = lnk;
        if (ctrl.clr_acc) acc_o = '0;
        if (ctrl.clr_lnk) lnk_o = 1'b0;
        if (ctrl.cpl_acc) acc_o = ~acc_o;
        if (ctrl.cpl_lnk) lnk_o = ~lnk_o;
    end

endmodule

// File: rtl/opr_second.sv
`timescale 1ns/1ps
module opr_second
    import opr_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  ctrl_t          ctrl,
    input  logic [W-1:0]   acc,
    input  logic           lnk,
    input  logic [W-1:0]   sw,
    input  logic           user,
    output logic [W-1:0]   acc_o,
    output logic           lnk_o,
    output logic           halt_o,
    output logic           trap_o
);

    localparam int unsigned CW      = W + 1;
    localparam int unsigned HALF    = W / 2;
    localparam int unsigned ROT_MAX = 2;

    logic [CW-1:0] chain_inc;
    logic [CW-1:0] chain_swp;
    logic [CW-1:0] rol [1:ROT_MAX];
    logic [CW-1:0] ror [1:ROT_MAX];
    logic [CW-1:0] chain_mv;

    // Increment runs ahead of the move network.
    assign chain_inc = (ctrl.grp == GRP_ONE && ctrl.inc) ? ({lnk, acc} + CW'(1)) : {lnk, acc};
    assign chain_swp = {chain_inc[CW-1], chain_inc[HALF-1:0], chain_inc[W-1:HALF]};

    for (genvar d = 1; d <= ROT_MAX; d++) begin : g_rot
        assign rol[d] = {chain_inc[CW-1-d:0], chain_inc[CW-1:CW-d]};
        assign ror[d] = {chain_inc[d-1:0],    chain_inc[CW-1:d]};
    end

    always_comb begin
        case (ctrl.move)
            MV_SWAP: chain_mv = chain_swp;
            MV_ROL1: chain_mv = rol[1];
            MV_ROL2: chain_mv = rol[2];
            MV_ROR1: chain_mv = ror[1];
            MV_ROR2: chain_mv = ror[2];
            default: chain_mv = chain_inc;
        endcase
    end

    always_comb begin
        acc_o  = acc;
        lnk_o  = lnk;
        halt_o = 1'b0;
        trap_o = 1'b0;
        case (ctrl.grp)
            GRP_ONE: begin
                {lnk_o, acc_o} = chain_mv;
            end
            GRP_TWO: begin
                if (user) begin
                    trap_o = ctrl.osr || ctrl.hlt;
                end else begin
                    if (ctrl.osr) acc_o = acc | sw;
                    halt_o = ctrl.hlt;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/opr_unit.sv
`timescale 1ns/1ps
module opr_unit
    import opr_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr_in,
    input  logic [W-1:0]       acc_in,
    input  logic               lnk_in,
    input  logic [W-1:0]       sw_in,
    input  logic               user_in,
    input  logic               ph1_stb,
    input  logic               ph2_stb,
    output logic [W-1:0]       acc_out,
    output logic               lnk_out,
    output logic               skip_pulse,
    output logic               halt_pulse,
    output logic               trap_pulse
);

    ctrl_t        ctrl_d;
    ctrl_t        ctrl_q;
    logic         armed_q;
    logic         skip_pend_q;
    logic         user_q;
    logic [W-1:0] acc_q;
    logic         lnk_q;

    logic [W-1:0] acc_p1;
    logic         lnk_p1;
    logic         skip_p1;
    logic [W-1:0] acc_p2;
    logic         lnk_p2;
    logic         halt_p2;
    logic         trap_p2;

    opr_decode u_dec (
        .iw   (instr_in),
        .ctrl (ctrl_d)
    );

    opr_first #(.W(W)) u_first (
        .ctrl   (ctrl_d),
        .acc    (acc_in),
        .lnk    (lnk_in),
        .acc_o  (acc_p1),
        .lnk_o  (lnk_p1),
        .skip_o (skip_p1)
    );

    opr_second #(.W(W)) u_second (
        .ctrl   (ctrl_q),
        .acc    (acc_q),
        .lnk    (lnk_q),
        .sw     (sw_in),
        .user   (user_q),
        .acc_o  (acc_p2),
        .lnk_o  (lnk_p2),
        .halt_o (halt_p2),
        .trap_o (trap_p2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            armed_q     <= 1'b0;
            skip_pend_q <= 1'b0;
            user_q      <= 1'b0;
            acc_q       <= '0;
            lnk_q       <= 1'b0;
            skip_pulse  <= 1'b0;
            halt_pulse  <= 1'b0;
            trap_pulse  <= 1'b0;
        end else begin
            skip_pulse <= 1'b0;
            halt_pulse <= 1'b0;
            trap_pulse <= 1'b0;
            if (ph1_stb) begin
                if (ctrl_d.grp != GRP_NONE) begin
                    ctrl_q      <= ctrl_d;
                    armed_q     <= 1'b1;
                    skip_pend_q <= skip_p1;
                    user_q      <= user_in;
                    acc_q       <= acc_p1;
                    lnk_q       <= lnk_p1;
                end else begin
                    armed_q     <= 1'b0;
                end
            end else if (ph2_stb && armed_q) begin
                armed_q    <= 1'b0;
                acc_q      <= acc_p2;
                lnk_q      <= lnk_p2;
                skip_pulse <= skip_pend_q;
                halt_pulse <= halt_p2;
                trap_pulse <= trap_p2;
            end
        end
    end

    assign acc_out = acc_q;
    assign lnk_out = lnk_q;

endmodule

// File: rtl/opr_unit_chk.sv
`timescale 1ns/1ps
module opr_unit_chk #(
    parameter int unsigned W = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [11:0]   instr_in,
    input logic [W-1:0]  acc_in,
    input logic          lnk_in,
    input logic [W-1:0]  sw_in,
    input logic          user_in,
    input logic          ph1_stb,
    input logic          ph2_stb,
    input logic [W-1:0]  acc_out,
    input logic          lnk_out,
    input logic          skip_pulse,
    input logic          halt_pulse,
    input logic          trap_pulse
);

    logic foreign;
    assign foreign = (instr_in[11:9] != 3'd7) || (instr_in[8] && instr_in[0]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && !lnk_out && !skip_pulse && !halt_pulse && !trap_pulse));

    // R2
    foreign_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph1_stb && foreign) |=> ($stable(acc_out) && $stable(lnk_out)
                                  && !skip_pulse && !halt_pulse && !trap_pulse));

    // R9
    halt_after_ph2_chk: assert property (@(posedge clk) disable iff (rst)
        halt_pulse |-> $past(ph2_stb));

    // R10
    halt_trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(halt_pulse && trap_pulse));

    // R11
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (skip_pulse || halt_pulse || trap_pulse) |=> !(skip_pulse || halt_pulse || trap_pulse));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ph1_stb && !ph2_stb) |=> ($stable(acc_out) && $stable(lnk_out)));

endmodule

bind opr_unit opr_unit_chk #(.W(W)) u_chk (.*);

// File: tb/opr_unit_bench.sv
`timescale 1ns/1ps
module opr_unit_bench;

    localparam int W = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [11:0]   instr_in;
    logic [W-1:0]  acc_in;
    logic          lnk_in;
    logic [W-1:0]  sw_in;
    logic          user_in;
    logic          ph1_stb;
    logic          ph2_stb;
    logic [W-1:0]  acc_out;
    logic          lnk_out;
    logic          skip_pulse;
    logic          halt_pulse;
    logic          trap_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [W-1:0] e_acc;
    logic         e_lnk;

    always #2 clk = ~clk;

    opr_unit #(.W(W)) u_opr_unit (
        .clk(clk), .rst(rst), .instr_in(instr_in), .acc_in(acc_in), .lnk_in(lnk_in),
        .sw_in(sw_in), .user_in(user_in), .ph1_stb(ph1_stb), .ph2_stb(ph2_stb),
        .acc_out(acc_out), .lnk_out(lnk_out), .skip_pulse(skip_pulse),
        .halt_pulse(halt_pulse), .trap_pulse(trap_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_opr(input logic [11:0] iw);
        return (iw[11:9] == 3'd7) && !(iw[8] && iw[0]);
    endfunction

    // returns {skip, link, acc}
    function automatic logic [13:0] m_first(input logic [11:0] iw, input logic [11:0] a, input logic l);
        logic [11:0] na;
        logic        nl;
        logic        sk;
        logic        c;
        na = a; nl = l; sk = 1'b0;
        if (!iw[8]) begin
            if (iw[7]) na = 12'o0000;
            if (iw[6]) nl = 1'b0;
            if (iw[5]) na = ~na;
            if (iw[4]) nl = ~nl;
        end else begin
            c  = (iw[6] & a[11]) | (iw[5] & (a == 12'o0)) | (iw[4] & l);
            sk = c ^ iw[3];
            if (iw[7]) na = 12'o0000;
        end
        return {sk, nl, na};
    endfunction

    // returns {trap, halt, link, acc}
    function automatic logic [14:0] m_second(input logic [11:0] iw, input logic [11:0] a, input logic l,
                                             input logic [11:0] s, input logic um);
        logic [12:0] ch;
        logic        h, t;
        ch = {l, a}; h = 1'b0; t = 1'b0;
        if (!iw[8]) begin
            if (iw[0]) ch = ch + 13'd1;
            case (iw[3:1])
                3'b001: ch = {ch[12], ch[5:0], ch[11:6]};
                3'b010: ch = {ch[11:0], ch[12]};
                3'b011: ch = {ch[10:0], ch[12:11]};
                3'b100: ch = {ch[0], ch[12:1]};
                3'b101: ch = {ch[1:0], ch[12:2]};
                default: ;
            endcase
        end else if (um) begin
            t = iw[2] | iw[1];
        end else begin
            if (iw[2]) ch[11:0] = ch[11:0] | s;
            h = iw[1];
        end
        return {t, h, ch};
    endfunction

    task automatic run_vec(input logic [11:0] iw, input logic [11:0] a, input logic l,
                           input logic [11:0] s, input logic um, input int gap, input string req);
        logic [13:0] r1;
        logic [14:0] r2;
        bit          ok_op;
        logic        e_skip;
        logic        e_halt;
        logic        e_trap;
        ok_op = is_opr(iw);
        @(negedge clk);
        instr_in = iw; acc_in = a; lnk_in = l; user_in = um; ph1_stb = 1'b1;
        r1 = m_first(iw, a, l);
        e_skip = 1'b0; e_halt = 1'b0; e_trap = 1'b0;
        if (ok_op) begin
            e_acc = r1[11:0]; e_lnk = r1[12]; e_skip = r1[13];
        end
        @(negedge clk);
        ph1_stb = 1'b0;
        acc_in = 12'($urandom); lnk_in = 1'($urandom); user_in = 1'($urandom);
        instr_in = 12'($urandom);
        check(acc_out == e_acc && lnk_out == e_lnk, {req, " phase1"}, {lnk_out, acc_out}, {e_lnk, e_acc});
        for (int i = 0; i < gap; i++) @(negedge clk);
        sw_in = s; ph2_stb = 1'b1;
        if (ok_op) begin
            r2 = m_second(iw, e_acc, e_lnk, s, um);
            e_acc = r2[11:0]; e_lnk = r2[12]; e_halt = r2[13]; e_trap = r2[14];
        end
        @(negedge clk);
        ph2_stb = 1'b0; sw_in = 12'($urandom);
        check(acc_out == e_acc && lnk_out == e_lnk, {req, " result"}, {lnk_out, acc_out}, {e_lnk, e_acc});
        check({skip_pulse, halt_pulse, trap_pulse} == {e_skip, e_halt, e_trap}, {req, " pulses"},
              {skip_pulse, halt_pulse, trap_pulse}, {e_skip, e_halt, e_trap});
        @(negedge clk);
        // R11: pulses drop, results hold
        check({skip_pulse, halt_pulse, trap_pulse} == 3'b000 && acc_out == e_acc && lnk_out == e_lnk,
              "R11 hold", {skip_pulse, halt_pulse, trap_pulse, lnk_out, acc_out}, {4'b0000, e_acc});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst = 1'b1; instr_in = '0; acc_in = 12'o7777; lnk_in = 1'b1; sw_in = '0;
        user_in = 1'b0; ph1_stb = 1'b0; ph2_stb = 1'b0;
        e_acc = '0; e_lnk = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        check(acc_out == '0 && !lnk_out && !skip_pulse && !halt_pulse && !trap_pulse, "R1 reset",
              {skip_pulse, halt_pulse, trap_pulse, lnk_out, acc_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(acc_out == '0 && !lnk_out, "R1 after reset", {lnk_out, acc_out}, 0);

        // R3
        run_vec(12'o7240, 12'o1234, 1'b1, 12'o0, 1'b0, 0, "R3 clear+complement acc");
        run_vec(12'o7300, 12'o5555, 1'b1, 12'o0, 1'b0, 1, "R3 clear acc and link");
        run_vec(12'o7060, 12'o0707, 1'b0, 12'o0, 1'b0, 0, "R3 complement both");
        // R4
        run_vec(12'o7001, 12'o7777, 1'b0, 12'o0, 1'b0, 0, "R4 carry sets link");
        run_vec(12'o7001, 12'o7777, 1'b1, 12'o0, 1'b0, 2, "R4 carry clears link");
        run_vec(12'o7001, 12'o0041, 1'b1, 12'o0, 1'b0, 0, "R4 plain increment");
        // R5
        run_vec(12'o7002, 12'o1277, 1'b1, 12'o0, 1'b0, 0, "R5 swap halves");
        run_vec(12'o7004, 12'o4001, 1'b0, 12'o0, 1'b0, 0, "R5 rotate left 1");
        run_vec(12'o7006, 12'o6001, 1'b1, 12'o0, 1'b0, 0, "R5 rotate left 2");
        run_vec(12'o7010, 12'o0003, 1'b0, 12'o0, 1'b0, 1, "R5 rotate right 1");
        run_vec(12'o7012, 12'o0003, 1'b1, 12'o0, 1'b0, 0, "R5 rotate right 2");
        run_vec(12'o7014, 12'o1357, 1'b1, 12'o0, 1'b0, 0, "R5 unused move code");
        // R6
        run_vec(12'o7005, 12'o3777, 1'b0, 12'o0, 1'b0, 0, "R6 increment then rotate");
        run_vec(12'o7013, 12'o7777, 1'b1, 12'o0, 1'b0, 0, "R6 increment then rotate right 2");
        // R7
        run_vec(12'o7440, 12'o0000, 1'b0, 12'o0, 1'b0, 0, "R7 zero test skips");
        run_vec(12'o7500, 12'o4000, 1'b0, 12'o0, 1'b0, 0, "R7 negative test skips");
        run_vec(12'o7420, 12'o0001, 1'b1, 12'o0, 1'b0, 0, "R7 link test skips");
        run_vec(12'o7410, 12'o0001, 1'b0, 12'o0, 1'b0, 0, "R7 inverted empty test skips");
        run_vec(12'o7450, 12'o0000, 1'b0, 12'o0, 1'b0, 0, "R7 inverted zero test holds");
        run_vec(12'o7640, 12'o0005, 1'b0, 12'o0, 1'b0, 0, "R7 test sees acc before clear");
        // R8
        run_vec(12'o7404, 12'o0012, 1'b0, 12'o7700, 1'b0, 0, "R8 switch OR");
        run_vec(12'o7604, 12'o5252, 1'b1, 12'o1357, 1'b0, 1, "R8 clear then switch load");
        // R9
        run_vec(12'o7402, 12'o0101, 1'b0, 12'o0, 1'b0, 0, "R9 halt pulse");
        // R10
        run_vec(12'o7404, 12'o0012, 1'b0, 12'o7700, 1'b1, 0, "R10 user switch OR trapped");
        run_vec(12'o7402, 12'o0012, 1'b0, 12'o0, 1'b1, 0, "R10 user halt trapped");
        run_vec(12'o7410, 12'o0012, 1'b0, 12'o0, 1'b1, 0, "R10 user plain skip no trap");
        // R2
        run_vec(12'o1234, 12'o7777, 1'b1, 12'o7777, 1'b0, 0, "R2 other opcode ignored");
        run_vec(12'o7403, 12'o7777, 1'b1, 12'o7777, 1'b0, 0, "R2 third group ignored");

        for (int v = 0; v < 400; v++) begin
            logic [11:0] iw;
            iw = 12'($urandom);
            if ((($urandom) & 32'd7) != 0) iw[11:9] = 3'd7;
            if ((($urandom) & 32'd15) == 0) iw[8:0] = 9'o001;
            run_vec(iw, 12'($urandom), 1'($urandom), 12'($urandom), 1'($urandom),
                    int'($urandom % 3), "R3-R10 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule